// File: doc/BRIEF.md
# Transmit/Receive DMA Bus Arbiter

This block decides which of two DMA requesters, the transmit path or the receive path, may drive a shared system-bus master port. Each path raises a request, receives a grant, and marks the end of its bus transaction with a one-cycle done pulse. A grant stays in place until the owning path signals done. Arbitration only happens while the port is free.

Three configuration inputs shape the choice. A mode input selects either fixed priority or weighted round-robin. A favour input names the path that is preferred in both modes. A 3-bit ratio k applies in weighted mode only. With both paths busy, it gives the favoured path k+1 consecutive grants and then one grant to the other path.

The weighting never holds the port idle. A lone requester is served at once. The burst position restarts whenever the configuration changes, and whenever the port is free with nobody asking.

Top module: `dma_path_arbiter`

## Requirements
- R1: While reset is active, and on the first cycle after it, neither grant is asserted.
- R2: Never are both grants asserted in the same cycle.
- R3: A grant stays asserted until the owning path's done input is high at a clock edge. It drops on that edge. A done pulse from the path that is not granted has no effect.
- R4: With the mode input at 1 (fixed priority) and both paths requesting on a free port, the favoured path is granted. Favour input 1 means transmit, and 0 means receive.
- R5: In fixed-priority mode the ratio input has no effect on the order of grants.
- R6: With the mode input at 0 (weighted) and both paths requesting continuously, the favoured path receives k+1 consecutive grants, where k is the ratio value 0 to 7. The other path then receives one grant, and the pattern repeats.
- R7: When the port is free and only one path requests, that path is granted on the next clock edge, whatever the position in the weighted burst.
- R8: A change of mode, favour or ratio restarts the weighted burst, so the next grants to the favoured path begin a fresh run of k+1.
- R9: A clock edge on which the port is free and neither path requests restarts the weighted burst.
- R10: Grants are registered: a request seen on a free port at one edge yields a grant visible after that edge. After a done, the port is free for one cycle before the next grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fixed | input | 1 | 1 = fixed priority, 0 = weighted round-robin |
| cfg_tx_first | input | 1 | 1 = transmit favoured, 0 = receive favoured |
| cfg_ratio | input | RATIO_W (3) | Weight k; the favoured path gets k+1 grants per other-path grant |
| tx_req | input | 1 | Transmit path requests the bus |
| tx_done | input | 1 | Transmit transaction finished (one-cycle pulse) |
| tx_gnt | output | 1 | Transmit path owns the bus |
| rx_req | input | 1 | Receive path requests the bus |
| rx_done | input | 1 | Receive transaction finished (one-cycle pulse) |
| rx_gnt | output | 1 | Receive path owns the bus |

## Verification
The bench aims at the burst-position corners. It checks the extreme ratios 0 and 7, and a ratio change part-way through a burst. A counter that failed to restart would hand out too few favoured grants before switching. It also drops both requests mid-burst and then resumes. A design that kept the stale position would give the other path its grant early in the new burst. A lone other-path request arriving mid-burst must win at once; a design that waited for its turn would leave the port idle. Finally, a grant is held while a stray done arrives from the idle path; a design that released on any done would hand over the bus in mid-transaction.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   // Which path currently holds the bus master port.
   typedef enum logic [1:0] {
      OWN_FREE = 2'd0,
      OWN_TX   = 2'd1,
      OWN_RX   = 2'd2
   } owner_e;

   // Path indices used by the per-path generate mapping.
   localparam int unsigned PATH_TX = 0;
   localparam int unsigned PATH_RX = 1;
   localparam int unsigned NUM_PATHS = 2;

endpackage

// File: rtl/dma_arb_cfg_watch.sv
// Registers the configuration and flags any cycle in which it differs
// from the value held on the previous edge.
module dma_arb_cfg_watch #(
   parameter int unsigned RATIO_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_fixed,
   input  logic               cfg_tx_first,
   input  logic [RATIO_W-1:0] cfg_ratio,
   output logic               cfg_changed
);
   localparam int unsigned CFG_W = RATIO_W + 2;

   logic [CFG_W-1:0] cfg_now;
   logic [CFG_W-1:0] cfg_q;

   assign cfg_now = {cfg_fixed, cfg_tx_first, cfg_ratio};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         cfg_q <= cfg_now;
      end
   end

   assign cfg_changed = (cfg_now != cfg_q);
endmodule

// File: rtl/dma_arb_weight.sv
// Decision logic plus the burst-position counter.  Requests arrive
// already sorted into the favoured and the other path.
module dma_arb_weight #(
   parameter int unsigned RATIO_W = 3,
   parameter bit          SAT_CNT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_fixed,
   input  logic [RATIO_W-1:0] cfg_ratio,
   input  logic               cfg_changed,
   input  logic               port_free,
   input  logic               fav_req,
   input  logic               oth_req,
   output logic               pick_fav,
   output logic               pick_oth
);
   localparam int unsigned CNT_W = RATIO_W + 1;

   logic [CNT_W-1:0] burst_cnt;
   logic [CNT_W-1:0] cnt_eff;
   logic [CNT_W-1:0] burst_len;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] cnt_inc;
   logic             fav_turn;

   // A configuration change restarts the burst in the same cycle.
   assign cnt_eff   = cfg_changed ? '0 : burst_cnt;
   assign burst_len = CNT_W'(cfg_ratio) + CNT_W'(1);
   assign fav_turn  = (cnt_eff < burst_len);

   // The counter variant is chosen at elaboration.  The saturating form
   // stops at the burst length while the favoured path runs alone.
   // The wrapping form restarts the burst instead.
   generate
      if (SAT_CNT) begin : g_sat
         assign cnt_inc = fav_turn ? (cnt_eff + CNT_W'(1)) : cnt_eff;
      end else begin : g_wrap
         assign cnt_inc = fav_turn ? (cnt_eff + CNT_W'(1)) : CNT_W'(1);
      end
   endgenerate

   always_comb begin
      pick_fav = 1'b0;
      pick_oth = 1'b0;
      if (cfg_fixed) begin
         pick_fav = fav_req;
         pick_oth = !fav_req && oth_req;
      end else if (fav_req && oth_req) begin
         pick_fav = fav_turn;
         pick_oth = !fav_turn;
      end else begin
         pick_fav = fav_req;
         pick_oth = oth_req;
      end
   end

   always_comb begin
      cnt_nxt = cnt_eff;
      if (port_free) begin
         if (!fav_req && !oth_req) begin
            cnt_nxt = '0;
         end else if (cfg_fixed) begin
            cnt_nxt = '0;
         end else if (pick_fav) begin
            cnt_nxt = cnt_inc;
         end else if (pick_oth) begin
            cnt_nxt = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_cnt <= '0;
      end else begin
         burst_cnt <= cnt_nxt;
      end
   end
endmodule

// File: rtl/dma_arb_owner.sv
// Holds the bus owner until its own done pulse.
module dma_arb_owner
   import dma_arb_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   take_tx,
   input  logic   take_rx,
   input  logic   tx_done,
   input  logic   rx_done,
   output owner_e owner,
   output logic   port_free
);
   owner_e owner_nxt;

   always_comb begin
      owner_nxt = owner;
      unique case (owner)
         OWN_FREE: begin
            if (take_tx) begin
               owner_nxt = OWN_TX;
            end else if (take_rx) begin
               owner_nxt = OWN_RX;
            end
         end
         OWN_TX: if (tx_done) owner_nxt = OWN_FREE;
         OWN_RX: if (rx_done) owner_nxt = OWN_FREE;
         default: owner_nxt = OWN_FREE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner <= OWN_FREE;
      end else begin
         owner <= owner_nxt;
      end
   end

   assign port_free = (owner == OWN_FREE);
endmodule

// File: rtl/dma_path_arbiter.sv
module dma_path_arbiter
   import dma_arb_pkg::*;
#(
   parameter int unsigned RATIO_W = 3,
   parameter bit          SAT_CNT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_fixed,
   input  logic               cfg_tx_first,
   input  logic [RATIO_W-1:0] cfg_ratio,
   input  logic               tx_req,
   input  logic               tx_done,
   output logic               tx_gnt,
   input  logic               rx_req,
   input  logic               rx_done,
   output logic               rx_gnt
);
   generate
      if (RATIO_W < 1 || RATIO_W > 6) begin : g_bad_ratio_w
         $error("dma_path_arbiter: RATIO_W must lie in 1..6");
      end
   endgenerate

   logic [NUM_PATHS-1:0] req_v;
   logic [NUM_PATHS-1:0] take_v;
   logic [NUM_PATHS-1:0] favoured_v;
   logic                 fav_req;
   logic                 oth_req;
   logic                 pick_fav;
   logic                 pick_oth;
   logic                 cfg_changed;
   logic                 port_free;
   owner_e               owner;

   assign req_v[PATH_TX] = tx_req;
   assign req_v[PATH_RX] = rx_req;
   assign favoured_v[PATH_TX] = cfg_tx_first;
   assign favoured_v[PATH_RX] = !cfg_tx_first;

   assign fav_req = |(req_v & favoured_v);
   assign oth_req = |(req_v & ~favoured_v);

   // Map the favoured/other decision back onto each path.
   generate
      for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
         assign take_v[p] = favoured_v[p] ? pick_fav : pick_oth;
      end
   endgenerate

   dma_arb_cfg_watch #(
      .RATIO_W(RATIO_W)
   ) u_cfg_watch (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_fixed   (cfg_fixed),
      .cfg_tx_first(cfg_tx_first),
      .cfg_ratio   (cfg_ratio),
      .cfg_changed (cfg_changed)
   );

   dma_arb_weight #(
      .RATIO_W(RATIO_W),
      .SAT_CNT(SAT_CNT)
   ) u_weight (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_fixed  (cfg_fixed),
      .cfg_ratio  (cfg_ratio),
      .cfg_changed(cfg_changed),
      .port_free  (port_free),
      .fav_req    (fav_req),
      .oth_req    (oth_req),
      .pick_fav   (pick_fav),
      .pick_oth   (pick_oth)
   );

   dma_arb_owner u_owner (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_tx  (take_v[PATH_TX]),
      .take_rx  (take_v[PATH_RX]),
      .tx_done  (tx_done),
      .rx_done  (rx_done),
      .owner    (owner),
      .port_free(port_free)
   );

   assign tx_gnt = (owner == OWN_TX);
   assign rx_gnt = (owner == OWN_RX);
endmodule

// File: rtl/dma_path_arbiter_chk.sv
module dma_path_arbiter_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_fixed,
   input logic cfg_tx_first,
   input logic tx_req,
   input logic tx_done,
   input logic tx_gnt,
   input logic rx_req,
   input logic rx_done,
   input logic rx_gnt
);
   logic both_free;
   assign both_free = !tx_gnt && !rx_gnt;

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_gnt && rx_gnt)); // R2

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_gnt && !tx_done) |=> tx_gnt); // R3

   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_gnt && !rx_done) |=> rx_gnt); // R3

   AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_gnt && tx_done) |=> !tx_gnt && !rx_gnt); // R10

   AST_RX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_gnt && rx_done) |=> !tx_gnt && !rx_gnt); // R10

   AST_FIXED_FAVOUR: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fixed && both_free && tx_req && rx_req)
      |=> (tx_gnt == $past(cfg_tx_first)) && (rx_gnt == !$past(cfg_tx_first))); // R4

   AST_LONE_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (both_free && tx_req && !rx_req) |=> tx_gnt); // R7

   AST_LONE_RX: assert property (@(posedge clk) disable iff (!rst_n)
      (both_free && rx_req && !tx_req) |=> rx_gnt); // R7

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (both_free && !tx_req && !rx_req) |=> both_free); // R10
endmodule

bind dma_path_arbiter dma_path_arbiter_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_fixed   (cfg_fixed),
   .cfg_tx_first(cfg_tx_first),
   .tx_req      (tx_req),
   .tx_done     (tx_done),
   .tx_gnt      (tx_gnt),
   .rx_req      (rx_req),
   .rx_done     (rx_done),
   .rx_gnt      (rx_gnt)
);

// File: tb/test_dma_path_arbiter.sv
module test_dma_path_arbiter;
   localparam int RATIO_W = 3;
   localparam int TX = 0;
   localparam int RX = 1;
   localparam int NONE = 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_fixed = 1'b0;
   logic               cfg_tx_first = 1'b0;
   logic [RATIO_W-1:0] cfg_ratio = '0;
   logic               tx_req = 1'b0;
   logic               tx_done = 1'b0;
   logic               tx_gnt;
   logic               rx_req = 1'b0;
   logic               rx_done = 1'b0;
   logic               rx_gnt;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dma_path_arbiter #(.RATIO_W(RATIO_W)) i_dma_path_arbiter (
      .clk(clk), .rst_n(rst_n), .cfg_fixed(cfg_fixed), .cfg_tx_first(cfg_tx_first),
      .cfg_ratio(cfg_ratio), .tx_req(tx_req), .tx_done(tx_done), .tx_gnt(tx_gnt),
      .rx_req(rx_req), .rx_done(rx_done), .rx_gnt(rx_gnt)
   );

   task automatic check(input bit ok, input string rq, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic int who_now();
      return tx_gnt ? TX : (rx_gnt ? RX : NONE);
   endfunction

   // Waits for a grant, ends that transaction, and returns the winner.
   task automatic serve(output int who);
      who = NONE;
      for (int i = 0; i < 6; i++) begin
         if (tx_gnt || rx_gnt) break;
         @(negedge clk);
      end
      if (tx_gnt && rx_gnt) check(1'b0, "R2", 3, 1);
      who = who_now();
      if (who == TX) tx_done = 1'b1;
      if (who == RX) rx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      rx_done = 1'b0;
      check(!tx_gnt && !rx_gnt, "R10 release", who_now(), NONE);
   endtask

   task automatic go_idle();
      tx_req = 1'b0;
      rx_req = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // Both paths request continuously; the expected order is built from
   // the requirement text, not from the design.
   task automatic run_pattern(input bit fixed, input bit txf, input int k,
                              input int n, input string rq);
      int fav;
      int oth;
      int pos;
      int got;
      int exp;
      go_idle();
      cfg_fixed = fixed;
      cfg_tx_first = txf;
      cfg_ratio = RATIO_W'(k);
      @(negedge clk);
      fav = txf ? TX : RX;
      oth = txf ? RX : TX;
      pos = 0;
      tx_req = 1'b1;
      rx_req = 1'b1;
      for (int i = 0; i < n; i++) begin
         if (fixed) begin
            exp = fav;
         end else if (pos < k + 1) begin
            exp = fav;
            pos++;
         end else begin
            exp = oth;
            pos = 0;
         end
         serve(got);
         check(got == exp, rq, got, exp);
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(!tx_gnt && !rx_gnt, "R1 in reset", who_now(), NONE);
      rst_n = 1'b1;
      @(negedge clk);
      check(!tx_gnt && !rx_gnt, "R1 after reset", who_now(), NONE);
   endtask

   task automatic t_fixed();
      run_pattern(1'b1, 1'b1, 0, 4, "R4 fixed tx favoured");
      run_pattern(1'b1, 1'b0, 0, 4, "R4 fixed rx favoured");
      run_pattern(1'b1, 1'b0, 7, 5, "R5 fixed ratio 7 ignored");
      run_pattern(1'b1, 1'b1, 3, 5, "R5 fixed ratio 3 ignored");
   endtask

   task automatic t_weighted();
      run_pattern(1'b0, 1'b1, 0, 6, "R6 weight 1:1 tx");
      run_pattern(1'b0, 1'b0, 2, 8, "R6 weight 3:1 rx");
      run_pattern(1'b0, 1'b1, 7, 18, "R6 weight 8:1 tx");
   endtask

   task automatic t_hold();
      go_idle();
      cfg_fixed = 1'b1;
      cfg_tx_first = 1'b1;
      tx_req = 1'b1;
      rx_req = 1'b1;
      @(negedge clk);
      check(tx_gnt && !rx_gnt, "R10 grant after one edge", who_now(), TX);
      for (int i = 0; i < 5; i++) begin
         if (i == 2) rx_done = 1'b1;
         @(negedge clk);
         rx_done = 1'b0;
         check(tx_gnt && !rx_gnt, "R3 grant held", who_now(), TX);
      end
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      check(!tx_gnt && !rx_gnt, "R3 dropped on done", who_now(), NONE);
   endtask

   task automatic t_lone();
      int got;
      go_idle();
      cfg_fixed = 1'b0;
      cfg_tx_first = 1'b1;
      cfg_ratio = 3'd3;
      @(negedge clk);
      tx_req = 1'b1;
      rx_req = 1'b1;
      serve(got);
      serve(got);
      // Mid-burst the favoured path withdraws: the other path wins at once.
      tx_req = 1'b0;
      @(negedge clk);
      check(rx_gnt && !tx_gnt, "R7 lone other mid-burst", who_now(), RX);
      rx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0;
      go_idle();
      cfg_fixed = 1'b1;
      @(negedge clk);
      rx_req = 1'b1;
      @(negedge clk);
      check(rx_gnt, "R7 lone non-favoured in fixed mode", who_now(), RX);
      serve(got);
   endtask

   task automatic t_idle_restart();
      int got;
      int exp_seq[4];
      exp_seq = '{TX, TX, TX, RX};
      go_idle();
      cfg_fixed = 1'b0;
      cfg_tx_first = 1'b1;
      cfg_ratio = 3'd2;
      @(negedge clk);
      tx_req = 1'b1;
      rx_req = 1'b1;
      serve(got);
      serve(got);
      go_idle();
      tx_req = 1'b1;
      rx_req = 1'b1;
      for (int i = 0; i < 4; i++) begin
         serve(got);
         check(got == exp_seq[i], "R9 burst restart after idle", got, exp_seq[i]);
      end
   endtask

   task automatic t_cfg_restart();
      int got;
      int exp_seq[5];
      exp_seq = '{TX, TX, TX, TX, RX};
      go_idle();
      cfg_fixed = 1'b0;
      cfg_tx_first = 1'b1;
      cfg_ratio = 3'd1;
      @(negedge clk);
      tx_req = 1'b1;
      rx_req = 1'b1;
      serve(got);
      check(got == TX, "R6 first favoured", got, TX);
      cfg_ratio = 3'd3;
      for (int i = 0; i < 5; i++) begin
         serve(got);
         check(got == exp_seq[i], "R8 burst restart on ratio change", got, exp_seq[i]);
      end
   endtask

   initial begin
      t_reset();
      t_fixed();
      t_weighted();
      t_hold();
      t_lone();
      t_idle_restart();
      t_cfg_restart();
      go_idle();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!finished) begin
         check(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule